// File: doc/BRIEF.md
# Three-Phase Definite-Time Overcurrent Stage

This block is one protection stage for a three-phase feeder. On each sample tick it compares three phase-current magnitudes with one pickup setting. It raises a per-phase start wherever the magnitude lies above that setting, unless second-harmonic inrush blocking suppresses it. Each phase start drives its own definite-time timer, and the timer's output is that phase's trip. The per-phase starts are ORed into a stage start, and the per-phase trips are ORed into a stage trip.

Harmonic blocking is switched on by an enable bit and has two modes. In the per-phase mode, each phase is blocked only by its own harmonic flag. In the all-phase mode, one any-phase flag blocks all three phases. The timers can be held by an external timer-block input. They can also be held by an autoreclose block, but only when that block is enabled by configuration and the stage is built as definite-time only. The operate delay and the reset time are counted in sample ticks. When a start drops briefly, the accumulated time is kept for the reset time, so an intermittent fault still trips.

Top module: `oc_stage`

## Requirements
- R1: On each tick, phase i's start (bit 0 = A, bit 1 = B, bit 2 = C of `start_ph`) is registered as 1 only when that phase's magnitude is strictly greater than `pickup` and the phase is not harmonic-blocked. An equal magnitude gives no start.
- R2: With `h2_en`=1 and `h2_all`=0, `h2_flag[i]` blocks only phase i, and `h2_any` has no effect.
- R3: With `h2_en`=1 and `h2_all`=1, `h2_any`=1 blocks all three phases, and the per-phase flags have no effect.
- R4: With `h2_en`=0, neither `h2_flag` nor `h2_any` affects any start.
- R5: Each start tick that is not held adds one to the phase count, which saturates at `op_delay`. The phase trip asserts at the tick where the count reaches `op_delay`, and it stays high while the start persists.
- R6: A trip drops at the same tick at which its start drops.
- R7: On ticks without a start, the count is kept until the `reset_time`-th consecutive such tick, where it is cleared. A start that returns earlier resumes from the kept count.
- R8: A tick with `tmr_blk`=1 forces all trips low and freezes the counts. Starts are not affected.
- R9: `ar_blk` acts like `tmr_blk` only when `ar_en`=1 and the parameter `DT_ONLY`=1 (the default). With `ar_en`=0 it has no effect.
- R10: `start_any` is the OR of `start_ph`, and `trip_any` is the OR of `trip_ph`.
- R11: A synchronous `rst` clears all starts, trips and counts.
- R12: Starts, trips and counts change only at clock edges where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe |
| mag_a | input | MAG_W | Phase A magnitude |
| mag_b | input | MAG_W | Phase B magnitude |
| mag_c | input | MAG_W | Phase C magnitude |
| pickup | input | MAG_W | Pickup threshold |
| op_delay | input | CNT_W | Operate delay in ticks |
| reset_time | input | CNT_W | Reset time in ticks |
| h2_en | input | 1 | Harmonic blocking enable for this stage |
| h2_all | input | 1 | 1 = all-phase harmonic blocking mode |
| h2_flag | input | 3 | Per-phase harmonic flags |
| h2_any | input | 1 | Any-phase harmonic flag |
| tmr_blk | input | 1 | External timer block |
| ar_blk | input | 1 | Autoreclose protection block |
| ar_en | input | 1 | Enable for the autoreclose block |
| start_ph | output | 3 | Per-phase starts |
| trip_ph | output | 3 | Per-phase trips |
| start_any | output | 1 | Three-phase start |
| trip_any | output | 1 | Three-phase trip |

## Verification
Several properties are checked on every cycle:
- no trip without its start,
- no change between ticks,
- no trip on the tick after a block or a dropped start,
- no start at or below pickup,
- no start in all-phase blocking mode while the any-phase flag is high.

Only the bench scenarios can show the timing that depends on history:
- the exact tick on which a trip rises,
- the count held and resumed across a short gap, and the count cleared after the reset time,
- the count frozen under a timer block,
- a harmonic flag that blocks its own phase and no other.

// File: rtl/oc_stage_pkg.sv
package oc_stage_pkg;
   localparam int NUM_PH = 3;
   typedef logic [NUM_PH-1:0] ph_vec_t;
endpackage

// File: rtl/oc_block_sel.sv
module oc_block_sel
   import oc_stage_pkg::*;
#(
   parameter bit DT_ONLY = 1'b1
) (
   input  logic    h2_en,
   input  logic    h2_all,
   input  ph_vec_t h2_flag,
   input  logic    h2_any,
   input  logic    tmr_blk,
   input  logic    ar_blk,
   input  logic    ar_en,
   output ph_vec_t start_blk,
   output logic    timer_hold
);
   logic ar_hold;

   generate
      if (DT_ONLY) begin : g_ar_gate
         assign ar_hold = ar_blk & ar_en;
      end else begin : g_no_ar
         logic unused_ar;
         assign unused_ar = ar_blk ^ ar_en;
         assign ar_hold   = 1'b0;
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NUM_PH; i++) begin
         if (!h2_en)
            start_blk[i] = 1'b0;
         else if (h2_all)
            start_blk[i] = h2_any;
         else
            start_blk[i] = h2_flag[i];
      end
   end

   assign timer_hold = tmr_blk | ar_hold;
endmodule

// File: rtl/oc_level_gate.sv
module oc_level_gate #(
   parameter int MAG_W = 16
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [MAG_W-1:0] pickup,
   input  logic             blk,
   output logic             start
);
   logic above;
   assign above = (mag > pickup);
   assign start = above & ~blk;
endmodule

// File: rtl/oc_dt_timer.sv
module oc_dt_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             start,
   input  logic             hold,
   input  logic [CNT_W-1:0] op_delay,
   input  logic [CNT_W-1:0] reset_time,
   output logic             trip
);
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] idle_q;
   logic [CNT_W:0]   idle_n;
   logic             trip_q;

   assign cnt_n  = (cnt_q >= op_delay) ? cnt_q : cnt_q + 1'b1;
   assign idle_n = {1'b0, idle_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         idle_q <= '0;
         trip_q <= 1'b0;
      end else if (tick) begin
         if (hold) begin
            trip_q <= 1'b0;
         end else if (start) begin
            idle_q <= '0;
            cnt_q  <= cnt_n;
            trip_q <= (cnt_n >= op_delay);
         end else begin
            trip_q <= 1'b0;
            if (idle_n >= {1'b0, reset_time}) begin
               cnt_q  <= '0;
               idle_q <= '0;
            end else begin
               idle_q <= idle_n[CNT_W-1:0];
            end
         end
      end
   end

   assign trip = trip_q;

   p_drop_with_start_r6: assert property (@(posedge clk) disable iff (rst)
      (tick && !start) |=> !trip);
   p_hold_clears_trip_r8: assert property (@(posedge clk) disable iff (rst)
      (tick && hold) |=> !trip);
   p_quiet_between_ticks_r12: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(trip) && $stable(cnt_q) && $stable(idle_q)));
endmodule

// File: rtl/oc_stage.sv
module oc_stage
   import oc_stage_pkg::*;
#(
   parameter int MAG_W   = 16,
   parameter int CNT_W   = 16,
   parameter bit DT_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic [MAG_W-1:0] mag_c,
   input  logic [MAG_W-1:0] pickup,
   input  logic [CNT_W-1:0] op_delay,
   input  logic [CNT_W-1:0] reset_time,
   input  logic             h2_en,
   input  logic             h2_all,
   input  logic [2:0]       h2_flag,
   input  logic             h2_any,
   input  logic             tmr_blk,
   input  logic             ar_blk,
   input  logic             ar_en,
   output logic [2:0]       start_ph,
   output logic [2:0]       trip_ph,
   output logic             start_any,
   output logic             trip_any
);
   generate
      if (MAG_W < 2 || MAG_W > 32) begin : g_bad_mag
         $error("oc_stage: MAG_W out of range");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("oc_stage: CNT_W out of range");
      end
   endgenerate

   logic [MAG_W-1:0] mag_v [NUM_PH];
   ph_vec_t          blk_v, st_comb, start_q, trip_v;
   logic             timer_hold;

   assign mag_v[0] = mag_a;
   assign mag_v[1] = mag_b;
   assign mag_v[2] = mag_c;

   oc_block_sel #(.DT_ONLY(DT_ONLY)) u_blk (
      .h2_en     (h2_en),
      .h2_all    (h2_all),
      .h2_flag   (h2_flag),
      .h2_any    (h2_any),
      .tmr_blk   (tmr_blk),
      .ar_blk    (ar_blk),
      .ar_en     (ar_en),
      .start_blk (blk_v),
      .timer_hold(timer_hold)
   );

   generate
      for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
         oc_level_gate #(.MAG_W(MAG_W)) u_gate (
            .mag   (mag_v[i]),
            .pickup(pickup),
            .blk   (blk_v[i]),
            .start (st_comb[i])
         );
         oc_dt_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .start     (st_comb[i]),
            .hold      (timer_hold),
            .op_delay  (op_delay),
            .reset_time(reset_time),
            .trip      (trip_v[i])
         );

         p_no_start_below_r1: assert property (@(posedge clk) disable iff (rst)
            (tick && (mag_v[i] <= pickup)) |=> !start_ph[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         start_q <= '0;
      else if (tick)
         start_q <= st_comb;
   end

   assign start_ph  = start_q;
   assign trip_ph   = trip_v;
   assign start_any = |start_q;
   assign trip_any  = |trip_v;

   p_trip_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
      ((trip_ph & ~start_ph) == 3'b000));
   p_all_phase_block_r3: assert property (@(posedge clk) disable iff (rst)
      (tick && h2_en && h2_all && h2_any) |=> (start_ph == 3'b000));
   p_ext_block_r8: assert property (@(posedge clk) disable iff (rst)
      (tick && tmr_blk) |=> (trip_ph == 3'b000));
   p_start_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(start_ph));
endmodule

// File: tb/oc_stage_bench.sv
module oc_stage_bench;
   localparam int MAG_W = 16;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst, tick;
   logic [MAG_W-1:0] mag_a, mag_b, mag_c, pickup;
   logic [CNT_W-1:0] op_delay, reset_time;
   logic             h2_en, h2_all, h2_any, tmr_blk, ar_blk, ar_en;
   logic [2:0]       h2_flag, start_ph, trip_ph;
   logic             start_any, trip_any;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   oc_stage u_oc_stage (
      .clk(clk), .rst(rst), .tick(tick),
      .mag_a(mag_a), .mag_b(mag_b), .mag_c(mag_c), .pickup(pickup),
      .op_delay(op_delay), .reset_time(reset_time),
      .h2_en(h2_en), .h2_all(h2_all), .h2_flag(h2_flag), .h2_any(h2_any),
      .tmr_blk(tmr_blk), .ar_blk(ar_blk), .ar_en(ar_en),
      .start_ph(start_ph), .trip_ph(trip_ph),
      .start_any(start_any), .trip_any(trip_any)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic defaults();
      tick = 0; mag_a = 0; mag_b = 0; mag_c = 0; pickup = 100;
      op_delay = 3; reset_time = 2; h2_en = 0; h2_all = 0; h2_flag = 0;
      h2_any = 0; tmr_blk = 0; ar_blk = 0; ar_en = 0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1;
      @(negedge clk) rst = 0;
   endtask

   task automatic tick_once();
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
   endtask

   task automatic set_mags(input int a, input int b, input int c);
      mag_a = MAG_W'(a); mag_b = MAG_W'(b); mag_c = MAG_W'(c);
   endtask

   task automatic t_reset();
      defaults(); set_mags(500, 500, 500); op_delay = 1;
      tick_once();
      do_reset();
      check("R11 reset starts", start_ph, 0);
      check("R11 reset trips", trip_ph, 0);
      set_mags(0, 0, 0); tick_once();
   endtask

   task automatic t_detect();
      defaults(); do_reset(); op_delay = 50;
      set_mags(101, 100, 99);
      @(negedge clk);
      check("R12 no tick no start", start_ph, 0);
      tick_once();
      check("R1 strict above pickup", start_ph, 3'b001);
      check("R10 start_any", start_any, 1);
      repeat (3) @(negedge clk);
      check("R12 held between ticks", start_ph, 3'b001);
      set_mags(0, 0, 300); tick_once();
      check("R1 phase C", start_ph, 3'b100);
   endtask

   task automatic t_dt_timing();
      defaults(); do_reset(); op_delay = 3; set_mags(200, 0, 200);
      tick_once(); check("R5 tick1 no trip", trip_ph, 0);
      tick_once(); check("R5 tick2 no trip", trip_ph, 0);
      tick_once(); check("R5 tick3 trip", trip_ph, 3'b101);
      check("R10 trip_any", trip_any, 1);
      tick_once(); check("R5 trip persists", trip_ph, 3'b101);
      set_mags(0, 0, 200); tick_once();
      check("R6 trip drops with start", trip_ph, 3'b100);
   endtask

   task automatic t_h2_single();
      defaults(); do_reset(); op_delay = 50; set_mags(200, 200, 200);
      h2_flag = 3'b010; h2_any = 1; tick_once();
      check("R4 disabled h2 ignored", start_ph, 3'b111);
      h2_en = 1; tick_once();
      check("R2 own phase only", start_ph, 3'b101);
   endtask

   task automatic t_h2_three();
      defaults(); do_reset(); op_delay = 50; set_mags(200, 200, 200);
      h2_en = 1; h2_all = 1; h2_flag = 3'b111; h2_any = 0; tick_once();
      check("R3 per-phase flags ignored", start_ph, 3'b111);
      h2_any = 1; tick_once();
      check("R3 any flag blocks all", start_ph, 3'b000);
      check("R3 start_any low", start_any, 0);
   endtask

   task automatic t_tmr_block();
      defaults(); do_reset(); op_delay = 3; set_mags(200, 0, 0);
      tick_once(); tick_once();
      tmr_blk = 1; tick_once(); tick_once();
      check("R8 start unaffected", start_ph, 3'b001);
      check("R8 trip held off", trip_ph, 0);
      tmr_blk = 0; tick_once();
      check("R8 count frozen then resumed", trip_ph, 3'b001);
      tmr_blk = 1; tick_once();
      check("R8 block drops trip", trip_ph, 0);
   endtask

   task automatic t_ar_block();
      defaults(); do_reset(); op_delay = 1; set_mags(0, 200, 0);
      ar_blk = 1; ar_en = 0; tick_once();
      check("R9 ar disabled no effect", trip_ph, 3'b010);
      ar_en = 1; tick_once();
      check("R9 ar enabled blocks", trip_ph, 0);
      ar_blk = 0; tick_once();
      check("R9 ar released", trip_ph, 3'b010);
   endtask

   task automatic t_reset_time();
      defaults(); do_reset(); op_delay = 4; reset_time = 3; set_mags(200, 0, 0);
      tick_once(); tick_once();
      set_mags(0, 0, 0); tick_once(); tick_once();
      set_mags(200, 0, 0); tick_once();
      check("R7 resume no trip yet", trip_ph, 0);
      tick_once();
      check("R7 resumed count trips", trip_ph, 3'b001);
      do_reset();
      tick_once(); tick_once();
      set_mags(0, 0, 0); tick_once(); tick_once(); tick_once();
      set_mags(200, 0, 0); tick_once(); tick_once();
      check("R7 cleared count no trip", trip_ph, 0);
      tick_once(); tick_once();
      check("R7 full delay after clear", trip_ph, 3'b001);
   endtask

   initial begin
      rst = 1; defaults();
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_detect();
      t_dt_timing();
      t_h2_single();
      t_h2_three();
      t_tmr_block();
      t_ar_block();
      t_reset_time();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule